// File: doc/BRIEF.md
# Non-Blocking Data-Cache Access Pipeline

This block is the control path of a non-blocking level-one data cache. Load and store requests from the load-store unit and refill responses from the next cache level enter one pipeline of three stages: lookup, data read and deallocate. Each stage takes one clock and nothing stalls. The lookup stage checks a tag/valid array, or a small file of outstanding-miss entries on a tag miss, and answers the requester at once with a hit or miss acknowledge. The data-read stage flags data ready for hits, asks the next level for lines that a new miss entry needs, and installs refilled lines. The deallocate stage wakes the load that waited on a refilled line and frees its miss entry.

Requests carry a line address, which is the byte address with the in-line offset removed, and a requester tag. A refill also carries the index of the miss entry it answers. Line data is not held here, so a refill is modelled only as a tag install. Victims are chosen per set by a tree pseudo-LRU. A configuration input can make every lookup hit without consulting the tags.

Top module: `nbc_access_pipe`

## Requirements
- R1: A request accepted at clock edge k is in lookup between edges k and k+1, in data read between k+1 and k+2, and in deallocate between k+2 and k+3. At most one request enters per clock.
- R2: A refill takes no lookup action. It raises no lookup acknowledge, leaves both event counters unchanged, and does not touch the replacement state.
- R3: A demand request that matches a valid tag gets a hit acknowledge in its lookup cycle, with no miss entry and no next-level request. The matched way becomes most recently used.
- R4: On a tag miss where no miss entry holds the request's line and every entry is busy, the request gets a miss acknowledge. Nothing is allocated and no next-level request follows. Once a refill frees an entry, the same request allocates normally.
- R5: A store that misses in the tags is acknowledged as a hit. It takes the line's miss entry, allocating the lowest-numbered free one if none exists, and marks that entry modified.
- R6: A load that misses in the tags and whose entry has no data yet is acknowledged as a miss. It becomes the entry's waiting request, replacing any earlier waiter. A missing load with no entry allocates the lowest-numbered free entry. A load whose entry already has its data is acknowledged as a hit.
- R7: In the data-read cycle, a request acknowledged as a hit raises data ready with its requester tag. A request that allocated a new miss entry raises a next-level request carrying that entry index and the line address.
- R8: A refill installs its line in the data-read cycle. It reuses the way that already holds the tag if there is one. The next lookup of that line hits.
- R9: In the deallocate cycle, a refill whose entry is live releases that entry's waiting load by tag, if one exists, and frees the entry. A refill naming a free entry releases nothing.
- R10: The install victim is the lowest-numbered invalid way. In a full set it is the leaf reached by walking the per-set tree from the root, where node bit 0 means go to the left (lower-numbered) half. A use sets each node on the way's path to point away from it.
- R11: While the force-hit input is high, every demand lookup is acknowledged as a hit and counted as a hit, with no allocation and no replacement update.
- R12: Each demand lookup increments exactly one counter: the hit counter on a tag hit or forced hit, and the miss counter otherwise. A store miss counts as a miss.
- R13: After reset no tag or miss entry is valid, both counters read zero, and no acknowledge, ready, next-level request or release is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_hit | input | 1 | Treat every demand lookup as a hit |
| req_valid | input | 1 | A request enters the pipeline this clock |
| req_refill | input | 1 | The request is a refill response |
| req_store | input | 1 | The demand request is a store (0 = load) |
| req_line | input | LINE_W | Line address; low log2(SETS) bits select the set |
| req_id | input | ID_W | Requester tag of a demand request |
| req_entry | input | log2(ENTRIES) | Miss-entry index that a refill answers |
| lk_ack_valid | output | 1 | Lookup acknowledge |
| lk_ack_hit | output | 1 | Acknowledge result: 1 hit, 0 miss |
| lk_ack_id | output | ID_W | Requester tag of the acknowledge |
| rd_ready_valid | output | 1 | Data ready for a hit request |
| rd_ready_id | output | ID_W | Requester tag of the ready request |
| fill_req_valid | output | 1 | Next-level line request |
| fill_req_entry | output | log2(ENTRIES) | Miss entry that awaits the line |
| fill_req_line | output | LINE_W | Line address requested |
| rel_valid | output | 1 | Waiting load released by a refill |
| rel_id | output | ID_W | Requester tag of the released load |
| hit_count | output | CNT_W | Demand lookups that hit |
| miss_count | output | CNT_W | Demand lookups that missed |

## Verification
The assertions watch, on every cycle, the relations between stages and the invariants of the arrays. No line sits in two ways of a set. Allocation goes only into an empty entry, and a retired entry is gone on the next cycle. A store marks its entry modified. Data ready follows only a hit acknowledge, and a busy file yields no next-level request. Refills leave the counters alone, while each demand lookup moves exactly one counter. The bench scenarios alone show the values: which entry is picked, which requester tag a refill wakes, that a replaced waiter is the one released, and which way the pseudo-LRU evicts after a given sequence of fills and hits.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  // Outcome of the lookup stage for a demand request
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_TAG_HIT,
    LK_NO_SLOT,
    LK_STORE_BUF,
    LK_LOAD_READY,
    LK_LOAD_WAIT
  } lk_dec_e;

  localparam int PLRU_MAX_LVL = 4;

  // Walk the tree from the root; bit 0 at a node means the victim lies left
  function automatic logic [3:0] plru_pick(input logic [14:0] bits, input int levels);
    int node;
    node = 1;
    for (int l = 0; l < PLRU_MAX_LVL; l++) begin
      if (l < levels) node = 2 * node + int'(bits[node-1]);
    end
    return 4'(node - (1 << levels));
  endfunction

  // Make every node on the path of 'way' point away from it
  function automatic logic [14:0] plru_mark(input logic [14:0] bits, input logic [3:0] way,
                                            input int levels);
    logic [14:0] b;
    int node;
    b = bits;
    node = 1;
    for (int l = 0; l < PLRU_MAX_LVL; l++) begin
      if (l < levels) begin
        logic d;
        d = way[levels-1-l];
        b[node-1] = ~d;
        node = 2 * node + int'(d);
      end
    end
    return b;
  endfunction

endpackage

// File: rtl/nbc_tag_store.sv
module nbc_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   look_set,
  input  logic [TAG_W-1:0]          look_tag,
  output logic                      look_hit,
  output logic [$clog2(WAYS)-1:0]   look_way,
  input  logic                      touch_en,
  input  logic [$clog2(SETS)-1:0]   touch_set,
  input  logic [$clog2(WAYS)-1:0]   touch_way,
  input  logic                      fill_en,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic [TAG_W-1:0]          fill_tag
);
  import nbc_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-2:0]  plru_q [SETS];
  logic [WAYS-2:0]  plru_d [SETS];

  logic [WAYS-1:0]  look_match;
  logic [WAYS-1:0]  fill_match;
  logic [WAY_W-1:0] fill_way;

  // Lookup compare
  always_comb begin
    look_way = '0;
    for (int w = 0; w < WAYS; w++)
      look_match[w] = vld_q[look_set][w] && (tag_q[look_set][w] == look_tag);
    for (int w = WAYS - 1; w >= 0; w--)
      if (look_match[w]) look_way = WAY_W'(w);
  end
  assign look_hit = |look_match;

  // Install way: existing tag, else lowest invalid, else tree victim
  always_comb begin
    logic [WAY_W-1:0] inv_way;
    logic             any_inv;
    logic [WAY_W-1:0] hit_way;
    inv_way = '0;
    hit_way = '0;
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      fill_match[w] = vld_q[fill_set][w] && (tag_q[fill_set][w] == fill_tag);
      if (!vld_q[fill_set][w]) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
      if (fill_match[w]) hit_way = WAY_W'(w);
    end
    if (|fill_match)  fill_way = hit_way;
    else if (any_inv) fill_way = inv_way;
    else              fill_way = plru_pick(15'(plru_q[fill_set]), WAY_W)[WAY_W-1:0];
  end

  // Replacement-state update: hit touch, then install touch
  always_comb begin
    logic [14:0] b;
    for (int s = 0; s < SETS; s++) begin
      b = 15'(plru_q[s]);
      if (touch_en && touch_set == SET_W'(s)) b = plru_mark(b, 4'(touch_way), WAY_W);
      if (fill_en && fill_set == SET_W'(s))   b = plru_mark(b, 4'(fill_way), WAY_W);
      plru_d[s] = b[WAYS-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= plru_d[s];
      if (fill_en) vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  // A line never occupies two ways of one set
  assert_single_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(look_match) <= 1);

  // An install leaves the chosen way valid
  assert_install_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]);

endmodule

// File: rtl/nbc_miss_file.sv
module nbc_miss_file #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 12,
  parameter int ID_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINE_W-1:0]            probe_line,
  output logic                         probe_hit,
  output logic [$clog2(ENTRIES)-1:0]   probe_idx,
  output logic                         probe_ready,
  output logic                         spare_any,
  output logic [$clog2(ENTRIES)-1:0]   spare_idx,
  input  logic                         alloc_en,
  input  logic [$clog2(ENTRIES)-1:0]   alloc_idx,
  input  logic [LINE_W-1:0]            alloc_line,
  input  logic                         dirty_en,
  input  logic [$clog2(ENTRIES)-1:0]   dirty_idx,
  input  logic                         park_en,
  input  logic [$clog2(ENTRIES)-1:0]   park_idx,
  input  logic [ID_W-1:0]              park_id,
  input  logic                         arrive_en,
  input  logic [$clog2(ENTRIES)-1:0]   arrive_idx,
  input  logic [$clog2(ENTRIES)-1:0]   rd_idx,
  output logic                         rd_live,
  output logic                         rd_parked,
  output logic [ID_W-1:0]              rd_park_id,
  input  logic                         retire_en,
  input  logic [$clog2(ENTRIES)-1:0]   retire_idx
);
  localparam int ENT_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_v, ent_arr, ent_mod, ent_park;
  logic [LINE_W-1:0]  ent_line [ENTRIES];
  logic [ID_W-1:0]    ent_pid  [ENTRIES];

  always_comb begin
    probe_hit = 1'b0;
    probe_idx = '0;
    spare_any = 1'b0;
    spare_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (ent_v[e] && ent_line[e] == probe_line) begin
        probe_hit = 1'b1;
        probe_idx = ENT_W'(e);
      end
      if (!ent_v[e]) begin
        spare_any = 1'b1;
        spare_idx = ENT_W'(e);
      end
    end
  end
  assign probe_ready = ent_arr[probe_idx];

  assign rd_live    = ent_v[rd_idx];
  assign rd_parked  = ent_park[rd_idx];
  assign rd_park_id = ent_pid[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_arr  <= '0;
      ent_mod  <= '0;
      ent_park <= '0;
    end else begin
      if (alloc_en) begin
        ent_v[alloc_idx]    <= 1'b1;
        ent_arr[alloc_idx]  <= 1'b0;
        ent_mod[alloc_idx]  <= 1'b0;
        ent_park[alloc_idx] <= 1'b0;
      end
      if (dirty_en) ent_mod[dirty_idx] <= 1'b1;
      if (park_en)  ent_park[park_idx] <= 1'b1;
      if (arrive_en && ent_v[arrive_idx]) ent_arr[arrive_idx] <= 1'b1;
      if (retire_en) ent_v[retire_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) ent_line[alloc_idx] <= alloc_line;
    if (park_en)  ent_pid[park_idx]   <= park_id;
  end

  // Allocation only takes an empty slot
  assert_alloc_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !ent_v[alloc_idx]);

  // A store miss leaves its entry modified
  assert_store_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en |=> ent_mod[$past(dirty_idx)]);

  // A retired entry is free on the next cycle
  assert_retire_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_en |=> !ent_v[$past(retire_idx)]);

endmodule

// File: rtl/nbc_access_pipe.sv
module nbc_access_pipe #(
  parameter int LINE_W  = 12,
  parameter int SETS    = 4,
  parameter int WAYS    = 4,
  parameter int ENTRIES = 4,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         force_hit,
  input  logic                         req_valid,
  input  logic                         req_refill,
  input  logic                         req_store,
  input  logic [LINE_W-1:0]            req_line,
  input  logic [ID_W-1:0]              req_id,
  input  logic [$clog2(ENTRIES)-1:0]   req_entry,
  output logic                         lk_ack_valid,
  output logic                         lk_ack_hit,
  output logic [ID_W-1:0]              lk_ack_id,
  output logic                         rd_ready_valid,
  output logic [ID_W-1:0]              rd_ready_id,
  output logic                         fill_req_valid,
  output logic [$clog2(ENTRIES)-1:0]   fill_req_entry,
  output logic [LINE_W-1:0]            fill_req_line,
  output logic                         rel_valid,
  output logic [ID_W-1:0]              rel_id,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             miss_count
);
  import nbc_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_W = $clog2(ENTRIES);
  localparam int TAG_W = LINE_W - SET_W;

  function automatic logic [SET_W-1:0] set_of(input logic [LINE_W-1:0] line);
    return line[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] line);
    return line[LINE_W-1:SET_W];
  endfunction

  // ---------------- stage registers ----------------
  logic              s1_v, s1_refill, s1_store;
  logic [LINE_W-1:0] s1_line;
  logic [ID_W-1:0]   s1_id;
  logic [ENT_W-1:0]  s1_ent;

  logic              s2_v, s2_refill, s2_hit, s2_alloc;
  logic [LINE_W-1:0] s2_line;
  logic [ID_W-1:0]   s2_id;
  logic [ENT_W-1:0]  s2_ent;

  logic              s3_v, s3_refill;
  logic [ENT_W-1:0]  s3_ent;

  // ---------------- named internal events ----------------
  logic              lk_active;
  logic              ts_hit;
  logic [WAY_W-1:0]  ts_way;
  logic              tag_hit;
  logic              mf_probe_hit, mf_probe_ready, mf_spare_any;
  logic [ENT_W-1:0]  mf_probe_idx, mf_spare_idx;
  logic              mf_rd_live, mf_rd_parked;
  logic [ID_W-1:0]   mf_rd_park_id;
  lk_dec_e           lk_dec;
  logic              lk_hit_rep, lk_alloc;
  logic [ENT_W-1:0]  lk_ent;
  logic              touch_en, install_en, retire_en;
  logic [CNT_W-1:0]  cnt_sum;

  assign lk_active = s1_v && !s1_refill;
  assign tag_hit   = force_hit || ts_hit;
  assign touch_en  = lk_active && !force_hit && ts_hit;

  nbc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_set  (set_of(s1_line)),
    .look_tag  (tag_of(s1_line)),
    .look_hit  (ts_hit),
    .look_way  (ts_way),
    .touch_en  (touch_en),
    .touch_set (set_of(s1_line)),
    .touch_way (ts_way),
    .fill_en   (install_en),
    .fill_set  (set_of(s2_line)),
    .fill_tag  (tag_of(s2_line))
  );

  // ---------------- lookup decision ----------------
  always_comb begin
    lk_dec   = LK_IDLE;
    lk_alloc = 1'b0;
    lk_ent   = mf_probe_idx;
    if (lk_active) begin
      if (tag_hit) begin
        lk_dec = LK_TAG_HIT;
      end else if (!mf_probe_hit && !mf_spare_any) begin
        lk_dec = LK_NO_SLOT;
      end else begin
        if (!mf_probe_hit) begin
          lk_alloc = 1'b1;
          lk_ent   = mf_spare_idx;
        end
        if (s1_store)                           lk_dec = LK_STORE_BUF;
        else if (mf_probe_hit && mf_probe_ready) lk_dec = LK_LOAD_READY;
        else                                     lk_dec = LK_LOAD_WAIT;
      end
    end
  end

  assign lk_hit_rep = (lk_dec == LK_TAG_HIT) || (lk_dec == LK_STORE_BUF) ||
                      (lk_dec == LK_LOAD_READY);

  assign lk_ack_valid = lk_active;
  assign lk_ack_hit   = lk_hit_rep;
  assign lk_ack_id    = s1_id;

  // ---------------- data-read stage ----------------
  assign rd_ready_valid = s2_v && !s2_refill && s2_hit;
  assign rd_ready_id    = s2_id;
  assign fill_req_valid = s2_v && !s2_refill && s2_alloc;
  assign fill_req_entry = s2_ent;
  assign fill_req_line  = s2_line;
  assign install_en     = s2_v && s2_refill;

  // ---------------- deallocate stage ----------------
  assign retire_en = s3_v && s3_refill && mf_rd_live;
  assign rel_valid = retire_en && mf_rd_parked;
  assign rel_id    = mf_rd_park_id;

  nbc_miss_file #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) u_mshr (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_line  (s1_line),
    .probe_hit   (mf_probe_hit),
    .probe_idx   (mf_probe_idx),
    .probe_ready (mf_probe_ready),
    .spare_any   (mf_spare_any),
    .spare_idx   (mf_spare_idx),
    .alloc_en    (lk_alloc),
    .alloc_idx   (lk_ent),
    .alloc_line  (s1_line),
    .dirty_en    (lk_dec == LK_STORE_BUF),
    .dirty_idx   (lk_ent),
    .park_en     (lk_dec == LK_LOAD_WAIT),
    .park_idx    (lk_ent),
    .park_id     (s1_id),
    .arrive_en   (install_en),
    .arrive_idx  (s2_ent),
    .rd_idx      (s3_ent),
    .rd_live     (mf_rd_live),
    .rd_parked   (mf_rd_parked),
    .rd_park_id  (mf_rd_park_id),
    .retire_en   (retire_en),
    .retire_idx  (s3_ent)
  );

  // ---------------- pipeline advance ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_refill <= 1'b0; s1_store <= 1'b0;
      s1_line <= '0; s1_id <= '0; s1_ent <= '0;
      s2_v <= 1'b0; s2_refill <= 1'b0; s2_hit <= 1'b0; s2_alloc <= 1'b0;
      s2_line <= '0; s2_id <= '0; s2_ent <= '0;
      s3_v <= 1'b0; s3_refill <= 1'b0; s3_ent <= '0;
    end else begin
      s1_v      <= req_valid;
      s1_refill <= req_refill;
      s1_store  <= req_store;
      s1_line   <= req_line;
      s1_id     <= req_id;
      s1_ent    <= req_entry;
      s2_v      <= s1_v;
      s2_refill <= s1_refill;
      s2_hit    <= lk_hit_rep;
      s2_alloc  <= lk_alloc;
      s2_line   <= s1_line;
      s2_id     <= s1_id;
      s2_ent    <= s1_refill ? s1_ent : lk_ent;
      s3_v      <= s2_v;
      s3_refill <= s2_refill;
      s3_ent    <= s2_ent;
    end
  end

  // ---------------- event counters ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (lk_active) begin
      if (tag_hit) hit_count  <= hit_count + 1'b1;
      else         miss_count <= miss_count + 1'b1;
    end
  end

  assign cnt_sum = hit_count + miss_count;

  // ---------------- assertions ----------------
  assert_refill_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_refill) |=> $stable(cnt_sum));

  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_active |=> cnt_sum == CNT_W'($past(cnt_sum) + 1'b1));

  assert_no_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ack_valid && !lk_ack_hit && !mf_probe_hit && !mf_spare_any) |=> !fill_req_valid);

  assert_ready_after_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_valid |-> $past(lk_ack_valid && lk_ack_hit));

  assert_forced_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_active && force_hit) |=> (rd_ready_valid && !fill_req_valid));

  assert_release_after_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(install_en));

endmodule

// File: tb/test_nbc_access_pipe.sv
module test_nbc_access_pipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_hit = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_refill = 1'b0;
  logic        req_store = 1'b0;
  logic [11:0] req_line = '0;
  logic [3:0]  req_id = '0;
  logic [1:0]  req_entry = '0;
  logic        lk_ack_valid, lk_ack_hit, rd_ready_valid, fill_req_valid, rel_valid;
  logic [3:0]  lk_ack_id, rd_ready_id, rel_id;
  logic [1:0]  fill_req_entry;
  logic [11:0] fill_req_line;
  logic [15:0] hit_count, miss_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // captured per operation
  int r_av, r_ah, r_aid, r_rdy, r_rid, r_fv, r_fe, r_fl, r_rv, r_rlid;

  always #2 clk = ~clk;

  nbc_access_pipe i_nbc_access_pipe (
    .clk(clk), .rst_n(rst_n), .force_hit(force_hit),
    .req_valid(req_valid), .req_refill(req_refill), .req_store(req_store),
    .req_line(req_line), .req_id(req_id), .req_entry(req_entry),
    .lk_ack_valid(lk_ack_valid), .lk_ack_hit(lk_ack_hit), .lk_ack_id(lk_ack_id),
    .rd_ready_valid(rd_ready_valid), .rd_ready_id(rd_ready_id),
    .fill_req_valid(fill_req_valid), .fill_req_entry(fill_req_entry),
    .fill_req_line(fill_req_line), .rel_valid(rel_valid), .rel_id(rel_id),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [11:0] ln(input int tag, input int set);
    return {10'(tag), 2'(set)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One request, followed through lookup, data read and deallocate (R1)
  task automatic op(input bit refill, input bit store, input logic [11:0] line,
                    input int id, input int ent);
    @(negedge clk);
    req_valid = 1'b1; req_refill = refill; req_store = store;
    req_line = line; req_id = 4'(id); req_entry = 2'(ent);
    @(negedge clk);
    req_valid = 1'b0;
    r_av = int'(lk_ack_valid); r_ah = int'(lk_ack_hit); r_aid = int'(lk_ack_id);
    @(negedge clk);
    r_rdy = int'(rd_ready_valid); r_rid = int'(rd_ready_id);
    r_fv = int'(fill_req_valid); r_fe = int'(fill_req_entry); r_fl = int'(fill_req_line);
    @(negedge clk);
    r_rv = int'(rel_valid); r_rlid = int'(rel_id);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "ack after reset", int'(lk_ack_valid), 0);
    chk("R13", "ready after reset", int'(rd_ready_valid), 0);
    chk("R13", "fill after reset", int'(fill_req_valid), 0);
    chk("R13", "release after reset", int'(rel_valid), 0);
    chk("R13", "hit count after reset", int'(hit_count), 0);
    chk("R13", "miss count after reset", int'(miss_count), 0);
  endtask

  task automatic t_miss_paths;
    op(0, 0, ln(1, 0), 1, 0);
    chk("R1", "lookup ack one cycle after entry", r_av, 1);
    chk("R1", "ack id", r_aid, 1);
    chk("R13", "first load misses", r_ah, 0);
    chk("R6", "load miss not ready", r_rdy, 0);
    chk("R7", "new entry requests line", r_fv, 1);
    chk("R7", "lowest free entry", r_fe, 0);
    chk("R7", "requested line", r_fl, int'(ln(1, 0)));
    op(0, 1, ln(2, 0), 2, 0);
    chk("R5", "store miss acked as hit", r_ah, 1);
    chk("R7", "store data ready", r_rdy, 1);
    chk("R7", "ready id", r_rid, 2);
    chk("R5", "store takes entry 1", r_fe, 1);
    op(0, 0, ln(1, 0), 3, 0);
    chk("R6", "second load to pending line misses", r_ah, 0);
    chk("R6", "no second line request", r_fv, 0);
  endtask

  task automatic t_refill;
    op(1, 0, ln(1, 0), 0, 0);
    chk("R2", "refill raises no lookup ack", r_av, 0);
    chk("R9", "refill releases waiter", r_rv, 1);
    chk("R9", "latest waiter released", r_rlid, 3);
    chk("R2", "hit count unchanged", int'(hit_count), 0);
    chk("R2", "miss count unchanged", int'(miss_count), 3);
    op(0, 0, ln(1, 0), 4, 0);
    chk("R8", "installed line hits", r_ah, 1);
    chk("R3", "hit raises ready", r_rdy, 1);
    chk("R3", "hit needs no line", r_fv, 0);
  endtask

  task automatic t_full_file;
    op(0, 0, ln(3, 1), 5, 0);
    chk("R6", "C takes freed entry 0", r_fe, 0);
    op(0, 0, ln(4, 1), 6, 0);
    chk("R6", "D takes entry 2", r_fe, 2);
    op(0, 0, ln(5, 1), 7, 0);
    chk("R6", "E takes entry 3", r_fe, 3);
    op(0, 0, ln(6, 1), 8, 0);
    chk("R4", "full file acks miss", r_ah, 0);
    chk("R4", "full file no line request", r_fv, 0);
    op(1, 0, ln(3, 1), 0, 0);
    chk("R9", "release C", r_rlid, 5);
    op(1, 0, ln(4, 1), 0, 2);
    chk("R9", "release D", r_rlid, 6);
    op(1, 0, ln(5, 1), 0, 3);
    chk("R9", "release E", r_rlid, 7);
    op(1, 0, ln(2, 0), 0, 1);
    chk("R9", "store entry releases nothing", r_rv, 0);
    op(0, 0, ln(6, 1), 8, 0);
    chk("R4", "retry allocates after free", r_fv, 1);
    chk("R4", "retry entry", r_fe, 0);
    op(1, 0, ln(6, 1), 0, 0);
    chk("R9", "release F", r_rlid, 8);
  endtask

  task automatic t_plru;
    for (int t = 10; t < 14; t++) begin
      op(1, 0, ln(t, 2), 0, 0);
      chk("R9", "refill on free entry releases nothing", r_rv, 0);
    end
    op(0, 0, ln(10, 2), 9, 0);
    chk("R3", "way 0 hit", r_ah, 1);
    // tree after fills 0..3 then hit on 0: root->right, node3->left => way 2
    op(1, 0, ln(14, 2), 0, 0);
    op(0, 0, ln(12, 2), 9, 0);
    chk("R10", "tag in way 2 evicted", r_ah, 0);
    chk("R10", "evicted line requested", r_fv, 1);
    op(0, 0, ln(10, 2), 10, 0);
    chk("R10", "way 0 kept", r_ah, 1);
    op(0, 0, ln(11, 2), 11, 0);
    chk("R10", "way 1 kept", r_ah, 1);
    op(0, 0, ln(13, 2), 12, 0);
    chk("R10", "way 3 kept", r_ah, 1);
    op(0, 0, ln(14, 2), 13, 0);
    chk("R10", "new line present", r_ah, 1);
    op(1, 0, ln(12, 2), 0, 0);
    chk("R9", "release probe", r_rlid, 9);
  endtask

  task automatic t_force;
    force_hit = 1'b1;
    op(0, 0, ln(20, 3), 10, 0);
    force_hit = 1'b0;
    chk("R11", "forced hit", r_ah, 1);
    chk("R11", "forced ready", r_rdy, 1);
    chk("R11", "forced no allocation", r_fv, 0);
    op(0, 0, ln(20, 3), 11, 0);
    chk("R11", "forced lookup installed nothing", r_ah, 0);
    chk("R11", "miss allocates after force", r_fv, 1);
    op(1, 0, ln(20, 3), 0, 0);
    chk("R9", "release after force test", r_rlid, 11);
  endtask

  task automatic t_counters;
    chk("R12", "hit count total", int'(hit_count), 7);
    chk("R12", "miss count total", int'(miss_count), 10);
  endtask

  initial begin
    t_reset;
    t_miss_paths;
    t_refill;
    t_full_file;
    t_plru;
    t_force;
    t_counters;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule